// File: doc/BRIEF.md
# Line Interface Command Register with Error Counter Snapshot

This block holds the one-shot command register of a single line interface channel. The host writes command bits through a simple register port. Hardware acts on each bit and then clears it. The host cannot clear a bit itself. Four of the bits are action commands: a transceiver reset, a bipolar-violation insertion, a PRBS error insertion and an elastic buffer centering. Each one is carried across two line-rate stages and then sent to the datapath as a single-cycle pulse on a line-enable tick.

The other two bits control error counter snapshots. The block keeps two 16-bit saturating counters, one for PRBS bit errors and one for code violations. The rising edge of a snapshot bit copies the live count into a holding register and restarts the live counter from zero. The snapshot bit stays set until the host reads the high byte of that holding register. Snapshot requests are refused while the automatic error-counter mode input is high. On a centering command the block also presents half of the selected elastic buffer size as the target depth.

Top module: `lic_cmd_ctrl`

## Requirements
- R1: After synchronous reset, the command register (address 0) reads 0x00, every holding register reads 0x0000 and no command pulse is asserted.
- R2: Writing a 1 to a command bit at address 0 sets that bit. Writing a 0 leaves a set bit unchanged. Bits 1 and 0 always read as 0.
- R3: For an action command written at clock edge E0 with the line enable high on every cycle, the matching pulse output is high for exactly one clock cycle after edge E3. The command bit reads 0 from that same edge onward.
- R4: The action bits map to these outputs: bit 7 drives `line_rst_p`, bit 6 drives `bpv_ins_p`, bit 5 drives `prbs_ins_p` and bit 4 drives `eb_center_p`. Several bits written together pulse on the same cycle, and no other output pulses.
- R5: Each error counter adds one for every clock edge on which both the line enable and its error input are high. The count stops at 0xFFFF and does not wrap.
- R6: Setting bit 3 (PRBS) or bit 2 (code violation) latches the live count into that counter's holding register one edge later and restarts the live count from 0. Address 1/2 hold the PRBS low/high bytes. Address 3/4 hold the code-violation low/high bytes.
- R7: A snapshot bit stays set through reads of its low byte. It clears on the edge where its high byte is read with `rd_en` high.
- R8: While `auto_cnt_mode` is 1, writes to bits 3 and 2 are ignored. The bits stay 0 and the holding registers keep their values.
- R9: On the edge after `eb_center_p` is high, `eb_center_depth` equals `eb_size` shifted right by one. It then holds that value.
- R10: Action commands advance only on line-enable ticks. A pulse rises on the third tick after the write, whatever the spacing between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_ce | input | 1 | Line-rate clock enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| auto_cnt_mode | input | 1 | Automatic error-counter mode; blocks snapshot bits |
| prbs_err_in | input | 1 | PRBS bit-error event |
| cv_err_in | input | 1 | Code-violation event |
| eb_size | input | 8 | Currently selected elastic buffer size |
| line_rst_p | output | 1 | Transceiver reset pulse |
| bpv_ins_p | output | 1 | Bipolar violation insertion pulse |
| prbs_ins_p | output | 1 | PRBS error insertion pulse |
| eb_center_p | output | 1 | Elastic buffer centering pulse |
| eb_center_depth | output | 8 | Centering target depth |

## Verification
The bench measures the exact edge at which each pulse appears. It does this with the line enable held high and again with the enable set to one tick in four. An off-by-one synchronizer would shift the pulse, and a missing enable gate would fire it early. It writes zeros over a pending snapshot bit to show the bit does not clear, and it reads the low byte to show that a release wired to the wrong address is caught. It drives more than 65,535 events so that a wrapping counter shows a small value. It takes a second snapshot to show that a live counter which was not cleared carries the old count forward. It also tries snapshot writes in automatic mode, which a missing gate would accept.

// File: rtl/lic_cmd_pkg.sv
package lic_cmd_pkg;

    localparam int REG_W   = 8;
    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int N_SHOT  = 4;

    // bit positions inside the command register
    localparam int B_RST      = 7;
    localparam int B_BPV      = 6;
    localparam int B_PRBS_INS = 5;
    localparam int B_CENTER   = 4;
    localparam int B_SNAP_PRB = 3;
    localparam int B_SNAP_CV  = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CMD     = 3'd0,
        A_PRBS_LO = 3'd1,
        A_PRBS_HI = 3'd2,
        A_CV_LO   = 3'd3,
        A_CV_HI   = 3'd4
    } reg_addr_e;

    // one-shot index i sits at register bit (7 - i)
    function automatic int shot_bit(input int idx);
        return B_RST - idx;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/lic_oneshot.sv
module lic_oneshot (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic set,
    output logic pending,
    output logic pulse
);
    logic s1, s2, fire;

    assign fire = ce && s2 && pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            s1      <= 1'b0;
            s2      <= 1'b0;
            pulse   <= 1'b0;
        end else begin
            pulse <= fire;
            if (set)       pending <= 1'b1;
            else if (fire) pending <= 1'b0;
            if (fire) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else if (ce) begin
                s1 <= pending;
                s2 <= s1 && pending;
            end
        end
    end

    // R3: a command pulse lasts a single clock
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R2: a pending bit only drops when its pulse is issued
    a_r2_hw_clear_only: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> pulse);

endmodule

// File: rtl/lic_err_counter.sv
module lic_err_counter
    import lic_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             err,
    input  logic             arm_set,
    input  logic             hi_rd,
    output logic             armed,
    output logic [CNT_W-1:0] hold
);
    logic [CNT_W-1:0] live;
    logic             armed_q;
    logic             snap;

    assign snap = armed && !armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live    <= '0;
            hold    <= '0;
            armed   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed;
            if (arm_set)    armed <= 1'b1;
            else if (hi_rd) armed <= 1'b0;
            if (snap) begin
                hold <= live;
                live <= '0;
            end else if (ce && err) begin
                live <= sat_inc(live);
            end
        end
    end

    // R5: a full counter never wraps
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (live == {CNT_W{1'b1}} && !snap) |=> live == {CNT_W{1'b1}});

    // R7: a snapshot bit is released only by a high-byte read
    a_r7_release_on_hi: assert property (@(posedge clk) disable iff (rst)
        $fell(armed) |-> $past(hi_rd));

endmodule

// File: rtl/lic_cmd_ctrl.sv
module lic_cmd_ctrl
    import lic_cmd_pkg::*;
#(
    parameter int EB_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_ce,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              auto_cnt_mode,
    input  logic              prbs_err_in,
    input  logic              cv_err_in,
    input  logic [EB_W-1:0]   eb_size,
    output logic              line_rst_p,
    output logic              bpv_ins_p,
    output logic              prbs_ins_p,
    output logic              eb_center_p,
    output logic [EB_W-1:0]   eb_center_depth
);
    localparam int HALF = CNT_W / 2;

    logic              wr_cmd;
    logic [N_SHOT-1:0] shot_pend, shot_pulse;
    logic              prb_armed, cv_armed;
    logic [CNT_W-1:0]  prb_hold, cv_hold;
    logic              snap_ok;
    logic [REG_W-1:0]  cmd_view;

    assign wr_cmd  = wr_en && (addr == A_CMD);
    assign snap_ok = wr_cmd && !auto_cnt_mode;

    for (genvar i = 0; i < N_SHOT; i++) begin : g_shot
        lic_oneshot u_shot (
            .clk     (clk),
            .rst     (rst),
            .ce      (line_ce),
            .set     (wr_cmd && wdata[shot_bit(i)]),
            .pending (shot_pend[i]),
            .pulse   (shot_pulse[i])
        );
    end

    assign line_rst_p  = shot_pulse[0];
    assign bpv_ins_p   = shot_pulse[1];
    assign prbs_ins_p  = shot_pulse[2];
    assign eb_center_p = shot_pulse[3];

    lic_err_counter u_prbs_cnt (
        .clk     (clk),
        .rst     (rst),
        .ce      (line_ce),
        .err     (prbs_err_in),
        .arm_set (snap_ok && wdata[B_SNAP_PRB]),
        .hi_rd   (rd_en && addr == A_PRBS_HI),
        .armed   (prb_armed),
        .hold    (prb_hold)
    );

    lic_err_counter u_cv_cnt (
        .clk     (clk),
        .rst     (rst),
        .ce      (line_ce),
        .err     (cv_err_in),
        .arm_set (snap_ok && wdata[B_SNAP_CV]),
        .hi_rd   (rd_en && addr == A_CV_HI),
        .armed   (cv_armed),
        .hold    (cv_hold)
    );

    always_comb begin
        cmd_view = '0;
        for (int i = 0; i < N_SHOT; i++) cmd_view[shot_bit(i)] = shot_pend[i];
        cmd_view[B_SNAP_PRB] = prb_armed;
        cmd_view[B_SNAP_CV]  = cv_armed;
    end

    always_comb begin
        unique case (addr)
            A_CMD:     rdata = cmd_view;
            A_PRBS_LO: rdata = prb_hold[HALF-1:0];
            A_PRBS_HI: rdata = prb_hold[CNT_W-1:HALF];
            A_CV_LO:   rdata = cv_hold[HALF-1:0];
            A_CV_HI:   rdata = cv_hold[CNT_W-1:HALF];
            default:   rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)              eb_center_depth <= '0;
        else if (eb_center_p) eb_center_depth <= eb_size >> 1;
    end

    // R8: a snapshot bit cannot be raised while automatic mode is on
    a_r8_auto_blocks: assert property (@(posedge clk) disable iff (rst)
        $rose(prb_armed) |-> !$past(auto_cnt_mode));

    // R9: centering target follows the selected buffer size
    a_r9_center_half: assert property (@(posedge clk) disable iff (rst)
        eb_center_p |=> eb_center_depth == ($past(eb_size) >> 1));

endmodule

// File: tb/tb_lic_cmd_ctrl.sv
module tb_lic_cmd_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_ce = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       auto_cnt_mode = 1'b0;
    logic       prbs_err_in = 1'b0, cv_err_in = 1'b0;
    logic [7:0] eb_size = 8'd0;
    logic       line_rst_p, bpv_ins_p, prbs_ins_p, eb_center_p;
    logic [7:0] eb_center_depth;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lic_cmd_ctrl dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int pulses();
        return {line_rst_p, bpv_ins_p, prbs_ins_p, eb_center_p};
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1; #1; d = rdata;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(3'd0, v); chk("R1 cmd", v, 8'h00);
        peek(3'd2, v); chk("R1 prbs hi", v, 8'h00);
        peek(3'd3, v); chk("R1 cv lo", v, 8'h00);
        chk("R1 pulses", pulses(), 0);
    endtask

    task automatic t_shot(input logic [7:0] d, input int exp_mask, input string r);
        logic [7:0] v;
        wr(3'd0, d);
        cycles(2);
        chk({r, " early"}, pulses(), 0);
        peek(3'd0, v); chk({r, " pending"}, v & 8'hF0, d & 8'hF0);
        cycles(1);
        chk({r, " R3 pulse"}, pulses(), exp_mask);
        peek(3'd0, v); chk("R3 bit cleared", v & 8'hF0, 0);
        cycles(1);
        chk("R3 one cycle", pulses(), 0);
    endtask

    task automatic t_no_sw_clear();
        logic [7:0] v;
        wr(3'd0, 8'h08);
        wr(3'd0, 8'h00);
        peek(3'd0, v); chk("R2 zero write", v, 8'h08);
        rd(3'd2, v);
        wr(3'd0, 8'hFF);
        peek(3'd0, v); chk("R2 low bits", v, 8'hFC);
        cycles(4);
        rd(3'd2, v); rd(3'd4, v);
        peek(3'd0, v); chk("R2 released", v, 8'h00);
    endtask

    task automatic events(input int n, input logic p, input logic c);
        @(negedge clk);
        prbs_err_in = p; cv_err_in = c;
        for (int i = 0; i < n; i++) @(negedge clk);
        prbs_err_in = 1'b0; cv_err_in = 1'b0;
    endtask

    task automatic t_snapshot();
        logic [7:0] lo, hi, v;
        events(300, 1'b1, 1'b0);
        wr(3'd0, 8'h08);
        cycles(1);
        peek(3'd1, lo); peek(3'd2, hi);
        chk("R6 prbs hold", {hi, lo}, 300);
        rd(3'd1, v);
        peek(3'd0, v); chk("R7 lo keeps bit", v, 8'h08);
        rd(3'd2, v);
        peek(3'd0, v); chk("R7 hi clears bit", v, 8'h00);
        events(5, 1'b1, 1'b1);
        wr(3'd0, 8'h0C);
        cycles(1);
        peek(3'd1, lo); peek(3'd2, hi);
        chk("R6 live restarted", {hi, lo}, 5);
        peek(3'd3, lo); peek(3'd4, hi);
        chk("R6 cv hold", {hi, lo}, 5);
        rd(3'd2, v); rd(3'd4, v);
    endtask

    task automatic t_saturate();
        logic [7:0] lo, hi, v;
        events(65540, 1'b0, 1'b1);
        wr(3'd0, 8'h04);
        cycles(1);
        peek(3'd3, lo); peek(3'd4, hi);
        chk("R5 saturate", {hi, lo}, 16'hFFFF);
        rd(3'd4, v);
    endtask

    task automatic t_auto_mode();
        logic [7:0] lo, hi, v;
        auto_cnt_mode = 1'b1;
        events(9, 1'b1, 1'b0);
        wr(3'd0, 8'h0C);
        cycles(2);
        peek(3'd0, v); chk("R8 bits ignored", v, 8'h00);
        peek(3'd1, lo); peek(3'd2, hi);
        chk("R8 hold kept", {hi, lo}, 5);
        auto_cnt_mode = 1'b0;
    endtask

    task automatic t_center();
        eb_size = 8'd64;
        t_shot(8'h10, 4'b0001, "R9 center");
        chk("R9 depth", eb_center_depth, 32);
        eb_size = 8'd8;
        cycles(2);
        chk("R9 depth held", eb_center_depth, 32);
    endtask

    task automatic t_sparse();
        int ticks = 0;
        int seen = -1;
        int width = 0;
        @(negedge clk);
        line_ce = 1'b0;
        wr(3'd0, 8'h40);
        for (int i = 0; i < 24; i++) begin
            line_ce = (i % 4 == 3);
            @(posedge clk);
            if (line_ce) ticks++;
            @(negedge clk);
            if (bpv_ins_p) begin
                width++;
                if (seen < 0) seen = ticks;
            end
        end
        line_ce = 1'b1;
        chk("R10 third tick", seen, 3);
        chk("R10 width", width, 1);
    endtask

    initial begin
        #1_900_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cycles(4);
        rst = 1'b0;
        t_reset();
        t_shot(8'h80, 4'b1000, "R4 reset");
        t_shot(8'h40, 4'b0100, "R4 bpv");
        t_shot(8'h20, 4'b0010, "R4 prbs");
        t_shot(8'hF0, 4'b1111, "R4 all");
        t_no_sw_clear();
        t_snapshot();
        t_saturate();
        t_auto_mode();
        t_center();
        t_sparse();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule